// File: doc/BRIEF.md
# Acknowledge Polling Host Sequencer

This block runs on the host side of a 2-wire bus. After a nonvolatile write has been issued to a slave and has completed on the bus, the slave ignores its address until the internal write cycle finishes. The sequencer waits for that cycle to end by polling. Each poll is a START condition followed by the slave address byte. A missing acknowledge means the slave is still busy. The sequencer then issues a STOP, so the bus returns to idle, and starts the next attempt.

When the slave acknowledges, one of two things happens. If a follow-on operation is pending, the sequencer keeps the bus and sends the supplied instruction byte straight away, with no STOP in between. Otherwise it issues a STOP and releases the bus. A parameter sets the maximum number of polls. If every allowed poll is refused, the sequencer issues a STOP and reports a timeout.

The sequencer does not drive the bus wires itself. It controls a byte-level bus master through a single request/done handshake, with one bus action outstanding at a time.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset the block is idle. `bm_req_o`, `busy_o`, `done_o`, `chained_o` and `timeout_o` are all low.
- R2: A high `go_i` while idle captures `slave_addr_i`, `instr_i` and `follow_on_i`. The first bus action is then a START (op 1), followed by a byte send (op 3) of the captured address.
- R3: When the address send completes with `bm_ack_i` low and the poll limit has not been reached, the next action is a STOP (op 2). A new START and address send follow it.
- R4: When the address is acknowledged and the captured follow-on flag is set, the next action is a byte send of the captured instruction with no STOP. The block then finishes with `chained_o` high and `timeout_o` low.
- R5: When the address is acknowledged and no follow-on is pending, the next action is a STOP. The block then finishes with `chained_o` and `timeout_o` low.
- R6: If `MAX_POLLS` consecutive address sends are refused, a STOP follows the last one and no further START is issued. The block finishes with `timeout_o` high and `chained_o` low.
- R7: There is one request at a time. While `bm_req_o` is high and `bm_done_i` is low, the request, `bm_op_o` and `bm_byte_o` hold their values. The op codes are 1 for START, 2 for STOP and 3 for byte send.
- R8: `done_o` is a one-cycle pulse in the cycle after the `bm_done_i` of the final action. `chained_o` and `timeout_o` hold their values until the next start. `go_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Begin polling; sampled only while idle |
| slave_addr_i | input | 8 | Address byte sent on each poll |
| instr_i | input | 8 | Instruction byte sent after the acknowledge |
| follow_on_i | input | 1 | A follow-on operation is pending |
| bm_req_o | output | 1 | Request to the byte-level master |
| bm_op_o | output | 2 | Requested action: 1 START, 2 STOP, 3 send byte |
| bm_byte_o | output | 8 | Byte for a send action |
| bm_done_i | input | 1 | One-cycle completion of the current request |
| bm_ack_i | input | 1 | Acknowledge seen on a send, valid with `bm_done_i` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| chained_o | output | 1 | The instruction was sent without a STOP |
| timeout_o | output | 1 | The poll limit was exceeded |

## Verification
After `bm_done_i`, the next request appears one clock later. Any new op and byte are therefore visible at the falling edge after that done. `done_o` goes high one clock after the final done and is low again one clock later. The bench's bus-master model completes each request after a varying delay. At each completion the monitor pops the expected action from a scoreboard queue. At each falling edge where `done_o` is high, it pops the expected `chained_o`/`timeout_o` pair and checks that `done_o` has dropped one edge later. Several idle cycles after each sequence, the bench confirms that the queues are empty and no request is pending.

// File: rtl/ack_poll_seq.sv
module ack_poll_seq #(
  parameter int MAX_POLLS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] slave_addr_i,
  input  logic [7:0] instr_i,
  input  logic       follow_on_i,
  output logic       bm_req_o,
  output logic [1:0] bm_op_o,
  output logic [7:0] bm_byte_o,
  input  logic       bm_done_i,
  input  logic       bm_ack_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       chained_o,
  output logic       timeout_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [1:0] OP_START = 2'd1, OP_STOP = 2'd2, OP_SEND = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_RETRY_STOP, S_INSTR, S_END_STOP} state_t;
  state_t state;

  logic [CW-1:0] polls;
  logic [7:0]    addr_q, instr_q;
  logic          pend_q, to_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      polls     <= '0;
      addr_q    <= '0;
      instr_q   <= '0;
      pend_q    <= 1'b0;
      to_q      <= 1'b0;
      done_o    <= 1'b0;
      chained_o <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (go_i) begin
          addr_q    <= slave_addr_i;
          instr_q   <= instr_i;
          pend_q    <= follow_on_i;
          polls     <= '0;
          to_q      <= 1'b0;
          chained_o <= 1'b0;
          timeout_o <= 1'b0;
          state     <= S_START;
        end
        S_START: if (bm_done_i) state <= S_ADDR;
        S_ADDR: if (bm_done_i) begin
          if (bm_ack_i) state <= pend_q ? S_INSTR : S_END_STOP;
          else begin
            polls <= polls + 1'b1;
            if (polls == CW'(MAX_POLLS - 1)) begin
              to_q  <= 1'b1;
              state <= S_END_STOP;
            end else state <= S_RETRY_STOP;
          end
        end
        S_RETRY_STOP: if (bm_done_i) state <= S_START;
        S_INSTR: if (bm_done_i) begin
          chained_o <= 1'b1;
          done_o    <= 1'b1;
          state     <= S_IDLE;
        end
        S_END_STOP: if (bm_done_i) begin
          timeout_o <= to_q;
          done_o    <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state != S_IDLE);
  assign bm_req_o  = busy_o;
  assign bm_byte_o = (state == S_INSTR) ? instr_q : addr_q;

  always_comb begin
    case (state)
      S_START:                  bm_op_o = OP_START;
      S_ADDR, S_INSTR:          bm_op_o = OP_SEND;
      S_RETRY_STOP, S_END_STOP: bm_op_o = OP_STOP;
      default:                  bm_op_o = 2'd0;
    endcase
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bm_req_o && bm_op_o == 2'd0);

  p_nack_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && bm_done_i && !bm_ack_i) |=> bm_req_o && bm_op_o == OP_STOP);

  p_ack_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && bm_done_i && bm_ack_i && pend_q) |=>
      bm_req_o && bm_op_o == OP_SEND && bm_byte_o == instr_q);

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && bm_done_i && bm_ack_i && !pend_q) |=> bm_req_o && bm_op_o == OP_STOP);

  p_timeout_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> done_o && !chained_o);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req_o && !bm_done_i) |=> bm_req_o && $stable(bm_op_o) && $stable(bm_byte_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/ack_poll_seq_test.sv
module ack_poll_seq_test;
  localparam int CLK_NS = 10;
  localparam int POLLS  = 4;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, follow = 1'b0;
  logic [7:0] addr = '0, instr = '0;
  logic bm_done = 1'b0, bm_ack = 1'b0;
  logic bm_req, busy, done, chained, timeout;
  logic [1:0] bm_op;
  logic [7:0] bm_byte;

  ack_poll_seq #(.MAX_POLLS(POLLS)) uut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .slave_addr_i(addr), .instr_i(instr),
    .follow_on_i(follow), .bm_req_o(bm_req), .bm_op_o(bm_op), .bm_byte_o(bm_byte),
    .bm_done_i(bm_done), .bm_ack_i(bm_ack), .busy_o(busy), .done_o(done),
    .chained_o(chained), .timeout_o(timeout));

  always #(CLK_NS/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  logic [9:0] exp_ops[$];
  logic [1:0] exp_res[$];
  int nack_target = 0, addr_seen = 0, wait_cnt = 0, done_seen = 0;
  logic [1:0] last_op = 2'd0;
  logic done_prev = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // bus-master model and operation monitor
  always @(negedge clk) begin
    cycles++;
    if (bm_done) begin
      bm_done = 1'b0;
      wait_cnt = 0;
    end else if (bm_req) begin
      wait_cnt++;
      if (wait_cnt > 1 + ((addr_seen + int'(last_op)) % 3)) begin
        logic [9:0] rec;
        rec = {bm_op, (bm_op == 2'd3) ? bm_byte : 8'h00};
        if (bm_op == 2'd3 && last_op == 2'd1) begin
          bm_ack = (addr_seen >= nack_target);
          addr_seen++;
        end else bm_ack = 1'b1;
        last_op = bm_op;
        bm_done = 1'b1;
        if (exp_ops.size() == 0) chk(1'b0, "R7", "unexpected bus action", int'(rec), 0);
        else begin
          logic [9:0] e;
          e = exp_ops.pop_front();
          chk(rec == e, "R2/R3/R4/R5/R6", "bus action op+byte", int'(rec), int'(e));
        end
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (done_prev) chk(!done, "R8", "done pulse width", int'(done), 0);
    if (done) begin
      if (exp_res.size() == 0) chk(1'b0, "R8", "unexpected done", 1, 0);
      else begin
        logic [1:0] e;
        e = exp_res.pop_front();
        chk({chained, timeout} == e, "R4/R5/R6", "chained,timeout", int'({chained, timeout}), int'(e));
      end
      done_seen++;
    end
    done_prev = done;
  end

  task automatic run(input int n, input bit f, input logic [7:0] a, input logic [7:0] ins, input bit poke);
    int start_seen;
    for (int i = 0; ; i++) begin
      exp_ops.push_back({2'd1, 8'h00});
      exp_ops.push_back({2'd3, a});
      if (i < n) begin
        exp_ops.push_back({2'd2, 8'h00});
        if (i + 1 == POLLS) begin exp_res.push_back(2'b01); break; end
      end else begin
        if (f) begin exp_ops.push_back({2'd3, ins}); exp_res.push_back(2'b10); end
        else   begin exp_ops.push_back({2'd2, 8'h00}); exp_res.push_back(2'b00); end
        break;
      end
    end
    nack_target = n;
    addr_seen = 0;
    start_seen = done_seen;
    @(negedge clk);
    go = 1'b1; addr = a; instr = ins; follow = f;
    @(negedge clk);
    go = 1'b0;
    chk(busy && bm_req && bm_op == 2'd1, "R2", "START requested after go", int'(bm_op), 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      go = 1'b1; addr = ~a; instr = ~ins; follow = ~f;   // R8: ignored while busy
      @(negedge clk);
      go = 1'b0;
    end
    for (int k = 0; k < 3000 && done_seen == start_seen; k++) @(negedge clk);
    chk(done_seen == start_seen + 1, "R8", "sequence finished", done_seen - start_seen, 1);
    repeat (4) @(negedge clk);
    chk(!bm_req && !busy, "R5/R6", "bus idle after finish", int'({bm_req, busy}), 0);
    chk(exp_ops.size() == 0 && exp_res.size() == 0, "R3", "scoreboard drained", exp_ops.size(), 0);
    exp_ops.delete();
    exp_res.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bm_req && !busy && !done && !chained && !timeout, "R1", "reset outputs",
        int'({bm_req, busy, done, chained, timeout}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bm_req && bm_op == 2'd0, "R1", "idle after reset", int'(bm_op), 0);
    run(0, 1'b1, 8'hA0, 8'h5C, 1'b0);          // R4 immediate ack, chained
    chk(chained && !timeout, "R8", "chained held", int'({chained, timeout}), 2);
    run(2, 1'b0, 8'hA2, 8'h11, 1'b0);          // R3 retries then R5 release
    run(POLLS - 1, 1'b1, 8'hA4, 8'hE7, 1'b0);  // last allowed poll acked
    run(POLLS + 2, 1'b1, 8'hA6, 8'h33, 1'b0);  // R6 timeout
    chk(timeout && !chained, "R6", "timeout held", int'({chained, timeout}), 1);
    run(1, 1'b0, 8'hA8, 8'h42, 1'b1);          // R8 go ignored while busy
    run(0, 1'b0, 8'h50, 8'h00, 1'b0);          // R5 immediate release
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule